// File: doc/BRIEF.md
# Event Counter Group Register File

This block is a bank of event counters that sits beside an address-translation unit. Each counter has a writable count register, an event-select register and a stream-filter register. Outside logic watches the translation traffic, and for each counter it supplies an increment strobe and a filter-match flag. The block counts an event only when the global run bit, the counter's enable bit, its strobe and its effective match flag are all high. It sets a sticky overflow bit when a counter wraps past all-ones. It drives a level interrupt while the interrupt control bit is on and an overflowed counter also has its interrupt enabled.

Software reaches the block through a simple word-addressed register port. Each write takes effect on the next clock edge, and a read returns data combinationally for the address presented. The enable, interrupt-enable and overflow masks never take a plain write. Each has a set address and a clear address that act only on the bits written as 1, so separate pieces of software can own different counters without read-modify-write races. A build-time option selects a single shared filter. In that option, counter 0's filter register, span bit and match flag govern every counter. The event-select and filter fields are presented on output ports for the external stream matcher.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter, the enable, interrupt-enable and overflow masks, the run bit (0xE04 bit 0) and the interrupt control bit (0xE50 bit 0) read as zero. The configuration word at 0xE00 reads counters-minus-one in [5:0], width-minus-one in [13:8], relocated-counter option in bit 20, message-interrupt option in bit 21 and shared-filter mode in bit 23, with all other bits zero.
- R2: Counter n is read and written at byte offset n*S, where S is 4 when the width is at most 32 and 8 otherwise. In the 8-byte case the upper bits sit in the word at n*S+4. Bits above the width read zero, and offsets past the last counter read zero.
- R3: The event-select register of counter n at 0x400+4n keeps bits [15:0] as the event number and bit 29 as the span select. Other bits read zero. The event number is driven on evtSelOut[16n+15:16n].
- R4: Writing 1s to 0xC00 sets counter-enable bits and writing 1s to 0xC20 clears them. Writing 1s to 0xC40 and 0xC60 does the same for the interrupt-enable bits. Zero bits and bits at or above the counter count have no effect, and each mask reads back at both of its addresses.
- R5: A counter advances by exactly one on each clock where the run bit, its enable bit, its strobe and its effective match flag are all 1, and it holds otherwise.
- R6: An increment from all-ones wraps the counter to zero and sets its overflow bit, which reads at 0xCC0. Writing 1s to 0xC80 clears only those bits. A wrap in the same cycle as a clear of that bit leaves the bit set.
- R7: irqOut is 1 exactly when the interrupt control bit is 1 and at least one counter has both its overflow bit and its interrupt-enable bit set.
- R8: In shared-filter mode, counter 0's filter word (0xA00) and span bit drive fltSidOut and fltSpanOut for every counter, and fltMatch[0] gates every counter. The filter registers of the other counters read zero and ignore writes. Otherwise counter n's filter word sits at 0xA00+4n.
- R9: The 128-bit supported-event map reads as four words at 0xE20, 0xE24, 0xE28 and 0xE2C, low word first. Bit e is 1 when event e is implemented.
- R10: A software write to a counter in the same cycle as a qualifying increment stores the written value, and that cycle adds no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address of the register access (word aligned) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| evtStrobe | input | NUM_CNT | Per-counter event occurred |
| fltMatch | input | NUM_CNT | Per-counter stream filter matched |
| evtSelOut | output | 16*NUM_CNT | Event number of each counter |
| fltSpanOut | output | NUM_CNT | Effective span select of each counter |
| fltSidOut | output | 32*NUM_CNT | Effective filter word of each counter |
| irqOut | output | 1 | Level overflow interrupt |

## Verification
The bench attacks the overflow path at its edges. It drives a wrap on the same clock as a clear of that bit, where a design that gives the clear priority would lose the event. It writes a clear of the wrong bit, where a design that clears all bits would drop the pending interrupt. It drives a counter write together with an increment, where the wrong priority leaves the stored value one too high. A second instance uses a 40-bit width in shared-filter mode to check the 8-byte stride, the zeroed upper bits and the gating of all counters by counter 0's match flag; a design that decoded the stride wrongly would alias two counters, and one that kept per-counter filters would count events the shared filter rejects.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

  localparam logic [11:0] OFS_EVT_BASE = 12'h400;
  localparam logic [11:0] OFS_FLT_BASE = 12'hA00;
  localparam logic [11:0] OFS_EN_SET   = 12'hC00;
  localparam logic [11:0] OFS_EN_CLR   = 12'hC20;
  localparam logic [11:0] OFS_IE_SET   = 12'hC40;
  localparam logic [11:0] OFS_IE_CLR   = 12'hC60;
  localparam logic [11:0] OFS_OVF_CLR  = 12'hC80;
  localparam logic [11:0] OFS_OVF_STAT = 12'hCC0;
  localparam logic [11:0] OFS_CONFIG   = 12'hE00;
  localparam logic [11:0] OFS_RUN      = 12'hE04;
  localparam logic [11:0] OFS_SUPP     = 12'hE20;
  localparam logic [11:0] OFS_IRQ_CTL  = 12'hE50;

  localparam int SPAN_BIT = 29;

  // Strobes from the decoder to the datapath, one register write per cycle.
  typedef struct packed {
    logic       wrCntLo;
    logic       wrCntHi;
    logic       wrEvt;
    logic       wrFilt;
    logic [5:0] idx;
    logic       enSet;
    logic       enClr;
    logic       ieSet;
    logic       ieClr;
    logic       ovfClr;
    logic       wrRun;
    logic       wrIrqCtl;
  } ecbStrobes_t;

endpackage

// File: rtl/ecb_decode.sv
module ecb_decode
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W = 32,
  parameter bit GLOBAL_FILTER = 1'b0,
  parameter bit HAS_MSI = 1'b0,
  parameter bit RELOC_CNT = 1'b0,
  parameter logic [127:0] SUPPORTED_EVT = 128'hFF
) (
  input  logic                          regWrEn,
  input  logic [11:0]                   regAddr,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [NUM_CNT-1:0][15:0]      evtReg,
  input  logic [NUM_CNT-1:0]            spanReg,
  input  logic [NUM_CNT-1:0][31:0]      fltReg,
  input  logic [NUM_CNT-1:0]            cntEn,
  input  logic [NUM_CNT-1:0]            intEn,
  input  logic [NUM_CNT-1:0]            ovf,
  input  logic                          gEn,
  input  logic                          irqEn,
  output ecbStrobes_t                   str,
  output logic [31:0]                   regRdData
);

  localparam bool_wide = 0;
  localparam int WIDE = (CNT_W > 32) ? 1 : 0;
  localparam int STRIDE_SH = WIDE ? 3 : 2;
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [31:0] CFG_WORD = {8'h0, GLOBAL_FILTER, 1'b0, HAS_MSI, RELOC_CNT,
                                      6'h0, 6'(CNT_W - 1), 2'b0, 6'(NUM_CNT - 1)};

  logic        aligned;
  logic [9:0]  cntSlot;
  logic [5:0]  regSlot;
  logic [IDX_W-1:0] cSel;
  logic [IDX_W-1:0] rSel;
  logic        cntHit;
  logic        cntHi;
  logic        evtHit;
  logic        fltHit;
  logic [63:0] cntWide;

  always_comb begin
    aligned = (regAddr[1:0] == 2'b00);
    cntSlot = regAddr[11:2] >> (STRIDE_SH - 2);
    regSlot = regAddr[7:2];
    cSel    = IDX_W'(cntSlot);
    rSel    = IDX_W'(regSlot);
    cntHi   = (WIDE != 0) && regAddr[2];
    cntHit  = aligned && (regAddr[11:10] == 2'b00) && (cntSlot < 10'(NUM_CNT));
    evtHit  = aligned && (regAddr[11:8] == OFS_EVT_BASE[11:8]) && (regSlot < 6'(NUM_CNT));
    fltHit  = aligned && (regAddr[11:8] == OFS_FLT_BASE[11:8]) && (regSlot < 6'(NUM_CNT))
              && (!GLOBAL_FILTER || regSlot == 6'd0);
  end

  // Write strobes
  always_comb begin
    str = '0;
    if (regWrEn && aligned) begin
      str.idx      = (regAddr[11:10] == 2'b00) ? cntSlot[5:0] : regSlot;
      str.wrCntLo  = cntHit && !cntHi;
      str.wrCntHi  = cntHit && cntHi;
      str.wrEvt    = evtHit;
      str.wrFilt   = fltHit;
      str.enSet    = (regAddr == OFS_EN_SET);
      str.enClr    = (regAddr == OFS_EN_CLR);
      str.ieSet    = (regAddr == OFS_IE_SET);
      str.ieClr    = (regAddr == OFS_IE_CLR);
      str.ovfClr   = (regAddr == OFS_OVF_CLR);
      str.wrRun    = (regAddr == OFS_RUN);
      str.wrIrqCtl = (regAddr == OFS_IRQ_CTL);
    end
  end

  // Readback
  always_comb begin
    regRdData = '0;
    cntWide   = 64'(cntVal[cSel]);
    if (cntHit) begin
      regRdData = cntHi ? cntWide[63:32] : cntWide[31:0];
    end else if (evtHit) begin
      regRdData = '0;
      regRdData[15:0] = evtReg[rSel];
      regRdData[SPAN_BIT] = spanReg[rSel];
    end else if (fltHit) begin
      regRdData = fltReg[rSel];
    end else begin
      unique case (regAddr)
        OFS_EN_SET, OFS_EN_CLR:     regRdData = 32'(cntEn);
        OFS_IE_SET, OFS_IE_CLR:     regRdData = 32'(intEn);
        OFS_OVF_CLR, OFS_OVF_STAT:  regRdData = 32'(ovf);
        OFS_CONFIG:                 regRdData = CFG_WORD;
        OFS_RUN:                    regRdData = {31'h0, gEn};
        OFS_IRQ_CTL:                regRdData = {31'h0, irqEn};
        12'hE20:                    regRdData = SUPPORTED_EVT[31:0];
        12'hE24:                    regRdData = SUPPORTED_EVT[63:32];
        12'hE28:                    regRdData = SUPPORTED_EVT[95:64];
        12'hE2C:                    regRdData = SUPPORTED_EVT[127:96];
        default:                    regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/ecb_counters.sv
module ecb_counters
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W = 32,
  parameter bit GLOBAL_FILTER = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ecbStrobes_t                   str,
  input  logic [31:0]                   wrData,
  input  logic [NUM_CNT-1:0]            evtStrobe,
  input  logic [NUM_CNT-1:0]            fltMatch,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CNT-1:0][15:0]      evtReg,
  output logic [NUM_CNT-1:0]            spanReg,
  output logic [NUM_CNT-1:0][31:0]      fltReg,
  output logic [NUM_CNT-1:0]            cntEn,
  output logic [NUM_CNT-1:0]            intEn,
  output logic [NUM_CNT-1:0]            ovf,
  output logic                          gEn,
  output logic                          irqEn,
  output logic                          irqOut
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [NUM_CNT-1:0] wrapHit;
  logic [NUM_CNT-1:0] dMask;

  assign dMask = wrData[NUM_CNT-1:0];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic        selHit;
    logic        swWrite;
    logic        effMatch;
    logic        incNow;
    logic [63:0] merged;

    assign selHit   = (str.idx == 6'(n));
    assign swWrite  = selHit && (str.wrCntLo || str.wrCntHi);
    assign effMatch = GLOBAL_FILTER ? fltMatch[0] : fltMatch[n];
    assign incNow   = gEn && cntEn[n] && evtStrobe[n] && effMatch;
    assign wrapHit[n] = incNow && !swWrite && (cntVal[n] == ALL_ONES);

    always_comb begin
      merged = 64'(cntVal[n]);
      if (str.wrCntLo) merged[31:0]  = wrData;
      if (str.wrCntHi) merged[63:32] = wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntVal[n] <= '0;
      end else if (swWrite) begin
        cntVal[n] <= CNT_W'(merged);
      end else if (incNow) begin
        cntVal[n] <= cntVal[n] + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtReg[n]  <= '0;
        spanReg[n] <= 1'b0;
      end else if (str.wrEvt && selHit) begin
        evtReg[n]  <= wrData[15:0];
        spanReg[n] <= wrData[SPAN_BIT];
      end
    end

    if (!GLOBAL_FILTER || n == 0) begin : g_flt
      always_ff @(posedge clk) begin
        if (!rstN) begin
          fltReg[n] <= '0;
        end else if (str.wrFilt && selHit) begin
          fltReg[n] <= wrData;
        end
      end
    end else begin : g_noflt
      assign fltReg[n] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn <= '0;
      intEn <= '0;
      ovf   <= '0;
      gEn   <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      cntEn <= (cntEn | (str.enSet ? dMask : '0)) & ~(str.enClr ? dMask : '0);
      intEn <= (intEn | (str.ieSet ? dMask : '0)) & ~(str.ieClr ? dMask : '0);
      ovf   <= (ovf & ~(str.ovfClr ? dMask : '0)) | wrapHit;
      if (str.wrRun)    gEn   <= wrData[0];
      if (str.wrIrqCtl) irqEn <= wrData[0];
    end
  end

  assign irqOut = irqEn && ((ovf & intEn) != '0);

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W = 32,
  parameter bit GLOBAL_FILTER = 1'b0,
  parameter bit HAS_MSI = 1'b0,
  parameter bit RELOC_CNT = 1'b0,
  parameter logic [127:0] SUPPORTED_EVT = 128'hFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [11:0]             regAddr,
  input  logic [31:0]             regWrData,
  output logic [31:0]             regRdData,
  input  logic [NUM_CNT-1:0]      evtStrobe,
  input  logic [NUM_CNT-1:0]      fltMatch,
  output logic [16*NUM_CNT-1:0]   evtSelOut,
  output logic [NUM_CNT-1:0]      fltSpanOut,
  output logic [32*NUM_CNT-1:0]   fltSidOut,
  output logic                    irqOut
);

  ecbStrobes_t                   str;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0][15:0]      evtReg;
  logic [NUM_CNT-1:0]            spanReg;
  logic [NUM_CNT-1:0][31:0]      fltReg;
  logic [NUM_CNT-1:0]            cntEn;
  logic [NUM_CNT-1:0]            intEn;
  logic [NUM_CNT-1:0]            ovf;
  logic                          gEn;
  logic                          irqEn;

  ecb_decode #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .GLOBAL_FILTER(GLOBAL_FILTER),
    .HAS_MSI(HAS_MSI), .RELOC_CNT(RELOC_CNT), .SUPPORTED_EVT(SUPPORTED_EVT)
  ) u_decode (
    .regWrEn(regWrEn), .regAddr(regAddr), .cntVal(cntVal), .evtReg(evtReg),
    .spanReg(spanReg), .fltReg(fltReg), .cntEn(cntEn), .intEn(intEn), .ovf(ovf),
    .gEn(gEn), .irqEn(irqEn), .str(str), .regRdData(regRdData)
  );

  ecb_counters #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .GLOBAL_FILTER(GLOBAL_FILTER)
  ) u_counters (
    .clk(clk), .rstN(rstN), .str(str), .wrData(regWrData), .evtStrobe(evtStrobe),
    .fltMatch(fltMatch), .cntVal(cntVal), .evtReg(evtReg), .spanReg(spanReg),
    .fltReg(fltReg), .cntEn(cntEn), .intEn(intEn), .ovf(ovf), .gEn(gEn),
    .irqEn(irqEn), .irqOut(irqOut)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_out
    localparam int SRC = GLOBAL_FILTER ? 0 : n;
    assign evtSelOut[16*n +: 16] = evtReg[n];
    assign fltSpanOut[n]         = spanReg[SRC];
    assign fltSidOut[32*n +: 32] = fltReg[SRC];
  end

endmodule

// File: rtl/ecb_checker.sv
module ecb_checker #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input logic [NUM_CNT-1:0]            ovf,
  input logic [NUM_CNT-1:0]            intEn,
  input logic                          gEn,
  input logic                          irqEn,
  input logic                          irqOut
);

  // R7: interrupt stays low with the control bit off
  assert_irq_ctl_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);

  // R7: interrupt stays low with no enabled overflow
  assert_irq_no_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((ovf & intEn) == '0) |-> !irqOut);

  // R5: with the run bit off and no register write, no counter moves
  assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!gEn && !regWrEn) |=> $stable(cntVal));

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
    // R5: without a write a counter advances by zero or one
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      !regWrEn |=> ((cntVal[n] - $past(cntVal[n])) <= CNT_W'(1)));

    // R6: an overflow bit only rises after the counter held all-ones
    assert_ovf_from_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovf[n]) |-> ($past(cntVal[n]) == {CNT_W{1'b1}}));
  end

endmodule

bind evt_counter_bank ecb_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .cntVal(cntVal), .ovf(ovf),
  .intEn(intEn), .gEn(gEn), .irqEn(irqEn), .irqOut(irqOut)
);

// File: tb/evt_counter_bank_bench.sv
`timescale 1ns/1ps
module evt_counter_bank_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Instance A: 4 counters, 32 bits, individual filters
  logic        aWr = 1'b0;
  logic [11:0] aAddr = '0;
  logic [31:0] aData = '0;
  logic [31:0] aRd;
  logic [3:0]  aStb = '0;
  logic [3:0]  aMat = '0;
  logic [63:0] aEvt;
  logic [3:0]  aSpan;
  logic [127:0] aSid;
  logic        aIrq;

  // Instance B: 2 counters, 40 bits, shared filter
  logic        bWr = 1'b0;
  logic [11:0] bAddr = '0;
  logic [31:0] bData = '0;
  logic [31:0] bRd;
  logic [1:0]  bStb = '0;
  logic [1:0]  bMat = '0;
  logic [31:0] bEvt;
  logic [1:0]  bSpan;
  logic [63:0] bSid;
  logic        bIrq;

  evt_counter_bank u_evt_counter_bank (
    .clk(clk), .rstN(rstN), .regWrEn(aWr), .regAddr(aAddr), .regWrData(aData),
    .regRdData(aRd), .evtStrobe(aStb), .fltMatch(aMat), .evtSelOut(aEvt),
    .fltSpanOut(aSpan), .fltSidOut(aSid), .irqOut(aIrq)
  );

  evt_counter_bank #(.NUM_CNT(2), .CNT_W(40), .GLOBAL_FILTER(1'b1)) u_evt_counter_bank_glob (
    .clk(clk), .rstN(rstN), .regWrEn(bWr), .regAddr(bAddr), .regWrData(bData),
    .regRdData(bRd), .evtStrobe(bStb), .fltMatch(bMat), .evtSelOut(bEvt),
    .fltSpanOut(bSpan), .fltSidOut(bSid), .irqOut(bIrq)
  );

  // {isWrite, req, addr, data, expected}
  localparam int NV = 27;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 4'd1,  12'hE00, 32'h0,        32'h00001F03}, // R1 config word
    {1'b0, 4'd1,  12'h000, 32'h0,        32'h0},        // R1 counter 0
    {1'b0, 4'd1,  12'hC00, 32'h0,        32'h0},        // R1 enables
    {1'b0, 4'd1,  12'hCC0, 32'h0,        32'h0},        // R1 overflow
    {1'b0, 4'd1,  12'hE04, 32'h0,        32'h0},        // R1 run bit
    {1'b1, 4'd2,  12'h008, 32'h12345678, 32'h0},
    {1'b0, 4'd2,  12'h008, 32'h0,        32'h12345678}, // R2 counter 2 at 8
    {1'b0, 4'd2,  12'h010, 32'h0,        32'h0},        // R2 past last counter
    {1'b1, 4'd3,  12'h404, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd3,  12'h404, 32'h0,        32'h2000FFFF}, // R3 fields kept
    {1'b1, 4'd4,  12'hC00, 32'h5,        32'h0},
    {1'b1, 4'd4,  12'hC00, 32'h2,        32'h0},
    {1'b0, 4'd4,  12'hC20, 32'h0,        32'h7},        // R4 set accumulates
    {1'b1, 4'd4,  12'hC20, 32'h4,        32'h0},
    {1'b0, 4'd4,  12'hC00, 32'h0,        32'h3},        // R4 clear one bit
    {1'b1, 4'd4,  12'hC00, 32'hF0,       32'h0},
    {1'b0, 4'd4,  12'hC00, 32'h0,        32'h3},        // R4 high bits ignored
    {1'b1, 4'd4,  12'hC40, 32'h9,        32'h0},
    {1'b1, 4'd4,  12'hC60, 32'h1,        32'h0},
    {1'b0, 4'd4,  12'hC60, 32'h0,        32'h8},        // R4 int enable
    {1'b1, 4'd8,  12'hA0C, 32'hDEADBEEF, 32'h0},
    {1'b0, 4'd8,  12'hA0C, 32'h0,        32'hDEADBEEF}, // R8 own filter word
    {1'b0, 4'd9,  12'hE20, 32'h0,        32'h000000FF}, // R9 map low word
    {1'b0, 4'd9,  12'hE28, 32'h0,        32'h0},        // R9 map third word
    {1'b1, 4'd5,  12'hE04, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd5,  12'hE04, 32'h0,        32'h1},        // R5 run bit only
    {1'b1, 4'd5,  12'hE04, 32'h0,        32'h0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrA(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); aWr = 1'b1; aAddr = a; aData = d;
    @(negedge clk); aWr = 1'b0;
  endtask

  task automatic rdA(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); aAddr = a; #1; d = aRd;
  endtask

  task automatic pulseA(input logic [3:0] m, input logic [3:0] f, input int cyc);
    @(negedge clk); aStb = m; aMat = f;
    repeat (cyc) @(negedge clk);
    aStb = '0; aMat = '0;
  endtask

  task automatic wrB(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bWr = 1'b1; bAddr = a; bData = d;
    @(negedge clk); bWr = 1'b0;
  endtask

  task automatic rdB(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bAddr = a; #1; d = bRd;
  endtask

  task automatic pulseB(input logic [1:0] m, input logic [1:0] f, input int cyc);
    @(negedge clk); bStb = m; bMat = f;
    repeat (cyc) @(negedge clk);
    bStb = '0; bMat = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 irq after reset", 64'(aIrq), 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        wrA(VEC[i][75:64], VEC[i][63:32]);
      end else begin
        rdA(VEC[i][75:64], r);
        checks++;
        if (r !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                   VEC[i][79:76], i, r, VEC[i][31:0]);
        end
      end
    end

    // R5: run bit off holds everything
    wrA(12'h000, 32'd10);
    pulseA(4'hF, 4'hF, 3);
    rdA(12'h000, r); chk("R5 stopped counter0", 64'(r), 64'd10);
    rdA(12'h004, r); chk("R5 stopped counter1", 64'(r), 64'd0);
    wrA(12'hE04, 32'h1);
    pulseA(4'h1, 4'h1, 4);
    rdA(12'h000, r); chk("R5 four increments", 64'(r), 64'd14);
    pulseA(4'h1, 4'h0, 3);
    rdA(12'h000, r); chk("R5 no match holds", 64'(r), 64'd14);
    pulseA(4'h4, 4'h4, 3);
    rdA(12'h008, r); chk("R5 disabled counter holds", 64'(r), 64'h12345678);

    // R3 and R8 output ports
    chk("R3 event number port", 64'(aEvt[31:16]), 64'hFFFF);
    chk("R3 span port", 64'(aSpan[1]), 64'h1);
    chk("R8 individual filter port", 64'(aSid[127:96]), 64'hDEADBEEF);

    // R6 wrap and overflow
    wrA(12'h004, 32'hFFFFFFFE);
    pulseA(4'h2, 4'h2, 2);
    rdA(12'h004, r); chk("R6 wrapped to zero", 64'(r), 64'h0);
    rdA(12'hCC0, r); chk("R6 overflow bit", 64'(r), 64'h2);
    chk("R7 no irq without int enable", 64'(aIrq), 64'h0);
    wrA(12'hC40, 32'h2);
    #1; chk("R7 no irq with control off", 64'(aIrq), 64'h0);
    wrA(12'hE50, 32'h1);
    #1; chk("R7 irq raised", 64'(aIrq), 64'h1);
    wrA(12'hC80, 32'h1);
    rdA(12'hCC0, r); chk("R6 clear of other bit", 64'(r), 64'h2);
    chk("R7 irq kept", 64'(aIrq), 64'h1);
    wrA(12'hC80, 32'h2);
    rdA(12'hCC0, r); chk("R6 cleared", 64'(r), 64'h0);
    chk("R7 irq dropped", 64'(aIrq), 64'h0);

    // R6 wrap on the same clock as a clear
    wrA(12'h004, 32'hFFFFFFFF);
    @(negedge clk); aWr = 1'b1; aAddr = 12'hC80; aData = 32'h2; aStb = 4'h2; aMat = 4'h2;
    @(negedge clk); aWr = 1'b0; aStb = '0; aMat = '0;
    rdA(12'hCC0, r); chk("R6 wrap beats clear", 64'(r), 64'h2);
    rdA(12'h004, r); chk("R6 counter wrapped", 64'(r), 64'h0);

    // R10 write beats increment
    @(negedge clk); aWr = 1'b1; aAddr = 12'h000; aData = 32'd100; aStb = 4'h1; aMat = 4'h1;
    @(negedge clk); aWr = 1'b0; aStb = '0; aMat = '0;
    rdA(12'h000, r); chk("R10 write wins", 64'(r), 64'd100);
    pulseA(4'h1, 4'h1, 1);
    rdA(12'h000, r); chk("R10 counts after write", 64'(r), 64'd101);

    // Shared-filter, 40-bit instance
    rdB(12'hE00, r); chk("R1 R8 config shared", 64'(r), 64'h00802701);
    wrB(12'h008, 32'hFFFFFFFF);
    wrB(12'h00C, 32'hFFFFFFFF);
    rdB(12'h00C, r); chk("R2 upper word masked", 64'(r), 64'hFF);
    rdB(12'h008, r); chk("R2 lower word", 64'(r), 64'hFFFFFFFF);
    rdB(12'h000, r); chk("R2 counter0 untouched", 64'(r), 64'h0);
    wrB(12'hA00, 32'h42);
    wrB(12'hA04, 32'h77);
    rdB(12'hA04, r); chk("R8 other filter reads zero", 64'(r), 64'h0);
    chk("R8 shared filter port", 64'(bSid[63:32]), 64'h42);
    wrB(12'h400, 32'h20000001);
    #1; chk("R8 shared span port", 64'(bSpan), 64'h3);
    chk("R3 own event number", 64'(bEvt[31:16]), 64'h0);
    wrB(12'hC00, 32'h3);
    wrB(12'hE04, 32'h1);
    pulseB(2'b10, 2'b10, 2);
    rdB(12'h008, r); chk("R8 gated by match0", 64'(r), 64'hFFFFFFFF);
    pulseB(2'b10, 2'b01, 1);
    rdB(12'h008, r); chk("R6 R8 wide wrap low", 64'(r), 64'h0);
    rdB(12'h00C, r); chk("R6 wide wrap high", 64'(r), 64'h0);
    rdB(12'hCC0, r); chk("R6 wide overflow", 64'(r), 64'h2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule